// File: doc/BRIEF.md
# Per-CPU Low-Storage Prefix Translator

This block turns a real address into an absolute address for one processor that shares main memory with other processors. Each processor owns a private prefix register. The prefix names one block of absolute storage. References to the lowest block of real storage are steered to that block. References that land inside the prefix block are steered back to absolute block zero. The two blocks therefore trade places. Every other block maps to itself.

The same mapping applies whether the address came from a program running without translation or from the dynamic translation unit. A mode input chooses 4 KiB or 8 KiB blocks. In 8 KiB mode the block field is one bit narrower, the offset is one bit wider, and the lowest prefix bit is not used. The result is registered, so it appears one cycle after the input.

Top module: `prefix_xlate`

## Requirements
- R1: Reset clears `aa_valid` and `aa_addr` to zero and sets the prefix register to zero, so the first translations after reset are identity mappings.
- R2: `aa_valid` equals the `ra_valid` of the previous cycle. A valid input gives its result on `aa_addr` exactly one cycle later.
- R3: With `wide_mode`=0, an address whose bits [23:12] are all zero leaves with bits [23:12] replaced by the 12-bit prefix. Bits [11:0] are kept.
- R4: With `wide_mode`=0, an address whose bits [23:12] equal a nonzero prefix leaves with bits [23:12] cleared to zero. Bits [11:0] are kept.
- R5: An address in neither block zero nor the prefix block leaves unchanged, in both modes.
- R6: When the prefix is zero, the output equals the input in both modes.
- R7: A prefix write with `pfx_we`=1 loads `pfx_wdata` at the clock edge. A translation presented in the same cycle uses the old prefix. The new prefix applies from the next presented address onward.
- R8: With `wide_mode`=1, an address whose bits [23:13] are all zero leaves with bits [23:13] replaced by prefix bits [11:1]. Bits [12:0] are kept, and prefix bit 0 is ignored.
- R9: With `wide_mode`=1, an address whose bits [23:13] equal a nonzero prefix[11:1] leaves with bits [23:13] cleared. Bits [12:0] are kept.
- R10: In a cycle with `ra_valid`=0, `aa_addr` keeps its value on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| ra_valid | input | 1 | Real address valid |
| ra_addr | input | 24 | Real address |
| wide_mode | input | 1 | 0 selects 4 KiB blocks, 1 selects 8 KiB blocks |
| pfx_we | input | 1 | Prefix register write enable |
| pfx_wdata | input | 12 | New prefix value |
| aa_valid | output | 1 | Absolute address valid |
| aa_addr | output | 24 | Absolute address, registered |

## Verification
The prefix register is the only state that is not visible directly. A corrupted prefix or a wrong write timing shows up on the next valid address in either swapped block. Such an address then leaves with the wrong block field, one cycle after it is presented. The bench mixes writes with translations in the same cycle, and keeps addresses flowing in both swapped blocks. Because of this, a prefix fault reaches `aa_addr` within a few cycles of being created. A fault in the valid pipeline or the hold behaviour shows up on the very next cycle.

// File: rtl/prefix_xlate_pkg.sv
package prefix_xlate_pkg;
   typedef enum logic {
      BLK_NARROW = 1'b0,
      BLK_WIDE   = 1'b1
   } blk_mode_e;

   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_LOW  = 2'd1,
      HIT_PFX  = 2'd2
   } hit_e;
endpackage

// File: rtl/pfx_store.sv
module pfx_store #(
   parameter int PFX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [PFX_W-1:0] wdata,
   output logic [PFX_W-1:0] pfx_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pfx_q <= '0;
      else if (we) pfx_q <= wdata;
   end
endmodule

// File: rtl/blk_swap.sv
module blk_swap
   import prefix_xlate_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int OFS_W   = 12,
   parameter bit WIDE_EN = 1'b1
) (
   input  logic [ADDR_W-1:0]        ra,
   input  logic [ADDR_W-OFS_W-1:0]  pfx,
   input  blk_mode_e                mode,
   output logic [ADDR_W-1:0]        aa
);
   localparam int PFX_W = ADDR_W - OFS_W;

   logic [ADDR_W-1:0] narrow_aa;
   hit_e              narrow_hit;

   always_comb begin
      narrow_hit = HIT_NONE;
      narrow_aa  = ra;
      if (ra[ADDR_W-1:OFS_W] == '0) begin
         narrow_hit = HIT_LOW;
         narrow_aa  = {pfx, ra[OFS_W-1:0]};
      end else if (ra[ADDR_W-1:OFS_W] == pfx) begin
         narrow_hit = HIT_PFX;
         narrow_aa  = {{PFX_W{1'b0}}, ra[OFS_W-1:0]};
      end
   end

   generate
      if (WIDE_EN) begin : g_wide
         localparam int WB_W = PFX_W - 1;
         logic [WB_W-1:0]   wpfx;
         logic [ADDR_W-1:0] wide_aa;
         hit_e              wide_hit;
         assign wpfx = pfx[PFX_W-1:1];
         always_comb begin
            wide_hit = HIT_NONE;
            wide_aa  = ra;
            if (ra[ADDR_W-1:OFS_W+1] == '0) begin
               wide_hit = HIT_LOW;
               wide_aa  = {wpfx, ra[OFS_W:0]};
            end else if (ra[ADDR_W-1:OFS_W+1] == wpfx) begin
               wide_hit = HIT_PFX;
               wide_aa  = {{WB_W{1'b0}}, ra[OFS_W:0]};
            end
         end
         always_comb begin
            if (mode == BLK_WIDE) aa = (wide_hit == HIT_NONE) ? ra : wide_aa;
            else                  aa = (narrow_hit == HIT_NONE) ? ra : narrow_aa;
         end
      end else begin : g_narrow
         blk_mode_e unused_mode;
         assign unused_mode = mode;
         assign aa = (narrow_hit == HIT_NONE) ? ra : narrow_aa;
      end
   endgenerate
endmodule

// File: rtl/prefix_xlate.sv
module prefix_xlate
   import prefix_xlate_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int OFS_W   = 12,
   parameter bit WIDE_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ra_valid,
   input  logic [ADDR_W-1:0]       ra_addr,
   input  logic                    wide_mode,
   input  logic                    pfx_we,
   input  logic [ADDR_W-OFS_W-1:0] pfx_wdata,
   output logic                    aa_valid,
   output logic [ADDR_W-1:0]       aa_addr
);
   localparam int PFX_W = ADDR_W - OFS_W;

   generate
      if (OFS_W < 1)       begin : g_bad_ofs  $error("OFS_W must be positive");         end
      if (PFX_W < 3)       begin : g_bad_pfx  $error("block field needs 3 or more bits"); end
   endgenerate

   logic [PFX_W-1:0]  pfx_q;
   logic [ADDR_W-1:0] mapped;
   blk_mode_e         mode;

   assign mode = blk_mode_e'(wide_mode);

   pfx_store #(.PFX_W(PFX_W)) u_pfx (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (pfx_we),
      .wdata (pfx_wdata),
      .pfx_q (pfx_q)
   );

   blk_swap #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .WIDE_EN(WIDE_EN)) u_swap (
      .ra   (ra_addr),
      .pfx  (pfx_q),
      .mode (mode),
      .aa   (mapped)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aa_valid <= 1'b0;
         aa_addr  <= '0;
      end else begin
         aa_valid <= ra_valid;
         if (ra_valid) aa_addr <= mapped;
      end
   end
endmodule

module prefix_xlate_chk #(
   parameter int ADDR_W  = 24,
   parameter int OFS_W   = 12,
   parameter bit WIDE_EN = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    ra_valid,
   input logic [ADDR_W-1:0]       ra_addr,
   input logic                    wide_mode,
   input logic                    pfx_we,
   input logic [ADDR_W-OFS_W-1:0] pfx_wdata,
   input logic                    aa_valid,
   input logic [ADDR_W-1:0]       aa_addr,
   input logic [ADDR_W-OFS_W-1:0] pfx_q
);
   localparam int PFX_W = ADDR_W - OFS_W;

   AST_VALID_SET:  assert property (@(posedge clk) disable iff (!rst_n) ra_valid |=> aa_valid);   // R2
   AST_VALID_CLR:  assert property (@(posedge clk) disable iff (!rst_n) !ra_valid |=> !aa_valid); // R2
   AST_LOW_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      ra_valid && !wide_mode && ra_addr[ADDR_W-1:OFS_W] == '0
      |=> aa_addr == {$past(pfx_q), $past(ra_addr[OFS_W-1:0])});                               // R3
   AST_BACK_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      ra_valid && !wide_mode && pfx_q != '0 && ra_addr[ADDR_W-1:OFS_W] == pfx_q
      |=> aa_addr[ADDR_W-1:OFS_W] == '0);                                                      // R4
   AST_ZERO_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
      ra_valid && pfx_q == '0 |=> aa_addr == $past(ra_addr));                                  // R6
   AST_PFX_LOAD:   assert property (@(posedge clk) disable iff (!rst_n)
      pfx_we |=> pfx_q == $past(pfx_wdata));                                                   // R7
   AST_LOW_WIDE:   assert property (@(posedge clk) disable iff (!rst_n)
      WIDE_EN && ra_valid && wide_mode && ra_addr[ADDR_W-1:OFS_W+1] == '0
      |=> aa_addr[ADDR_W-1:OFS_W+1] == $past(pfx_q[PFX_W-1:1]));                               // R8
   AST_HOLD_IDLE:  assert property (@(posedge clk) disable iff (!rst_n)
      !ra_valid |=> $stable(aa_addr));                                                         // R10
endmodule

bind prefix_xlate prefix_xlate_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .WIDE_EN(WIDE_EN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ra_valid  (ra_valid),
   .ra_addr   (ra_addr),
   .wide_mode (wide_mode),
   .pfx_we    (pfx_we),
   .pfx_wdata (pfx_wdata),
   .aa_valid  (aa_valid),
   .aa_addr   (aa_addr),
   .pfx_q     (pfx_q)
);

// File: tb/sim_prefix_xlate.sv
`timescale 1ns/1ps
module sim_prefix_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ra_valid = 1'b0;
   logic [23:0] ra_addr = '0;
   logic        wide_mode = 1'b0;
   logic        pfx_we = 1'b0;
   logic [11:0] pfx_wdata = '0;
   logic        aa_valid;
   logic [23:0] aa_addr;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int          m_pfx;
   logic        exp_v;
   logic [23:0] exp_a;

   always #2.5 clk = ~clk;

   prefix_xlate u0 (
      .clk(clk), .rst_n(rst_n), .ra_valid(ra_valid), .ra_addr(ra_addr),
      .wide_mode(wide_mode), .pfx_we(pfx_we), .pfx_wdata(pfx_wdata),
      .aa_valid(aa_valid), .aa_addr(aa_addr)
   );

   function automatic logic [23:0] model(int a, int p, bit w);
      int blk, pb, off, sh;
      sh  = w ? 13 : 12;
      blk = a >> sh;
      pb  = w ? (p >> 1) : p;
      off = a & ((1 << sh) - 1);
      if (blk == 0)       return 24'((pb << sh) | off);
      else if (blk == pb) return 24'(off);
      else                return 24'(a);
   endfunction

   task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(bit v, int a, bit we, int wd, bit w, string tag);
      ra_valid  = v;
      ra_addr   = 24'(a);
      pfx_we    = we;
      pfx_wdata = 12'(wd);
      wide_mode = w;
      exp_v = v;
      if (v) exp_a = model(a, m_pfx, w);
      if (we) m_pfx = wd;
      @(negedge clk);
      check("R2", {23'd0, aa_valid}, {23'd0, exp_v});
      check(v ? tag : "R10", aa_addr, exp_a);
   endtask

   initial begin
      m_pfx = 0; exp_v = 0; exp_a = '0;
      repeat (3) @(negedge clk);
      check("R1", {23'd0, aa_valid}, 24'd0);
      check("R1", aa_addr, 24'd0);
      rst_n = 1'b1;
      step(1, 'h000123, 0, 0, 0, "R1");
      step(1, 'hABC456, 0, 0, 0, "R6");
      step(1, 'h001FFF, 0, 0, 1, "R6");
      step(1, 'h000010, 1, 'h345, 0, "R7");
      step(1, 'h000010, 0, 0, 0, "R7");
      step(1, 'h000FFF, 0, 0, 0, "R3");
      step(1, 'h000000, 0, 0, 0, "R3");
      step(1, 'h345ABC, 0, 0, 0, "R4");
      step(1, 'h346ABC, 0, 0, 0, "R5");
      step(1, 'hFFF001, 0, 0, 0, "R5");
      step(0, 'h000777, 0, 0, 0, "R10");
      step(0, 'h345000, 0, 0, 1, "R10");
      step(1, 'h001ABC, 0, 0, 1, "R8");
      step(1, 'h000000, 0, 0, 1, "R8");
      step(1, 'h345ABC, 0, 0, 1, "R9");
      step(1, 'h344001, 0, 0, 1, "R9");
      step(1, 'h346001, 0, 0, 1, "R5");
      step(1, 'h001ABC, 1, 'h344, 1, "R7");
      step(1, 'h001ABC, 0, 0, 1, "R8");
      step(1, 'h001000, 1, 0, 0, "R7");
      step(1, 'h001000, 0, 0, 1, "R6");
      for (int i = 0; i < 400; i++) begin
         int a, p;
         a = $urandom & 'hFFFFFF;
         p = $urandom & 'hFFF;
         if (i % 4 == 0) a = a & 'h1FFF;
         if (i % 4 == 1) a = (m_pfx << 12) | (a & 'hFFF);
         step((i % 7) != 3, a, (i % 9) == 0, p, (i % 3) == 0, "R5");
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule